// File: doc/BRIEF.md
# Comparator-Triggered Timer Capture Controller

This block is the digital side of a single-slope measurement scheme. A free-running timer counts every clock. When the selected capture source shows a qualifying edge, the current count is latched into a capture register and a capture flag is raised. Software starts a conversion, typically from a timer compare or overflow event, by letting an external capacitor ramp. When the ramp crosses the unknown voltage, comparator 2 trips. Its edge ends the measurement, and the captured count encodes the voltage.

The capture source is either an external pin or comparator 2, chosen by a source-select bit. Writing a ramp conversion mode forces that bit to 1. The block keeps a sticky flag for each of the two comparators. It raises an analog request when the analog interrupt enable is set and either comparator flag is set. A two-source arbiter then merges the capture request and the analog request into one vectored interrupt. The capture request always wins. A pending analog request survives acknowledgement of the capture request and the clearing of the flags, and it ends only when it is itself acknowledged.

Top module: `cmp_capture_ctrl`

## Requirements
- R1: After reset, every output is 0: timer count, capture value, capture flag, both comparator flags, source select, mode, and interrupt request and vector. The interrupt enable and edge select are also 0.
- R2: The timer count increases by one on every clock and wraps from all ones to zero.
- R3: With source select 0, edges of the capture pin cause captures. With source select 1, edges of the comparator 2 output cause captures instead.
- R4: A control write updates the mode, the interrupt enable, the edge select and the source select together. When the written mode is 2 or 3, source select becomes 1 whatever value was written for it.
- R5: With edge select 1, a rising edge of the source causes a capture. With edge select 0, a falling edge causes a capture.
- R6: Every input passes through SYNC_STAGES flops. An input change made before clock edge k is captured at edge k+SYNC_STAGES. The capture value then holds the timer count from just before that edge, and the capture flag is set.
- R7: Comparator flag i sets on a rising edge of comparator i's synchronized output and then holds. It clears when a flag-clear write has bit i set, where bit 0 is comparator 1 and bit 1 is comparator 2. If a set and a clear happen in the same cycle, the set wins.
- R8: The analog request becomes pending on the clock after the interrupt enable is 1 while either comparator flag is 1.
- R9: Every capture makes the capture request pending. While the capture request is pending, the interrupt request is 1 and the vector is 0. The vector is 1 only when the analog request alone is pending.
- R10: An acknowledge clears only the request named by the vector at that moment. A pending analog request stays pending after the capture request is acknowledged, even if the comparator flags and the capture flag were cleared first.
- R11: The capture flag holds until a flag-clear write has bit 2 set. A capture in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_mode | input | MODE_W | Conversion mode to write |
| ctrl_src_sel | input | 1 | Source select to write (1 = comparator 2) |
| ctrl_irq_en | input | 1 | Analog interrupt enable to write |
| ctrl_edge_rise | input | 1 | Edge select to write (1 = rising) |
| flag_clr_we | input | 1 | Flag-clear write strobe |
| flag_clr | input | 3 | Write-1-to-clear mask: bit0 cmp1, bit1 cmp2, bit2 capture |
| cap_pin | input | 1 | External capture pin |
| cmp1_out | input | 1 | Comparator 1 output |
| cmp2_out | input | 1 | Comparator 2 output |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| timer_count | output | TMR_W | Free-running timer |
| cap_value | output | TMR_W | Captured timer value |
| cap_flag | output | 1 | Capture flag |
| cmp_flags | output | 2 | Sticky comparator flags |
| src_sel | output | 1 | Current capture source select |
| mode | output | MODE_W | Current conversion mode |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 1 | Vector: 0 capture, 1 analog |

## Verification
The bench builds the block with an 8-bit timer and the default two synchronizer stages. With 8 bits the count wraps every 256 clocks, so a short run covers many wraps and captures of counts near the wrap. The two-stage setting fixes the capture delay that the reference model uses to predict each capture value. Random changes on the pin and the comparators, together with random mode writes, cover both capture sources, both edge polarities and the forced switch of the source select. Random flag clears and acknowledges landing in the same cycle as sets cover the set-wins cases and the analog request that must survive the capture request.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic {
      VEC_CAPTURE = 1'b0,
      VEC_ANALOG  = 1'b1
   } irq_vec_e;

   localparam int unsigned CLR_CMP1 = 0;
   localparam int unsigned CLR_CMP2 = 1;
   localparam int unsigned CLR_CAP  = 2;

   function automatic logic is_ramp_mode(input logic [7:0] m);
      return (m == 8'd2) || (m == 8'd3);
   endfunction
endpackage

// File: rtl/cc_sync.sv
module cc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cc_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], din};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;
endmodule

// File: rtl/cc_capture.sv
module cc_capture #(
   parameter int unsigned TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_evt,
   input  logic             cap_clr,
   output logic [TMR_W-1:0] timer_count,
   output logic [TMR_W-1:0] cap_value,
   output logic             cap_flag
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer_count <= '0;
         cap_value   <= '0;
         cap_flag    <= 1'b0;
      end else begin
         timer_count <= timer_count + ONE;
         if (cap_evt) cap_value <= timer_count;
         cap_flag <= (cap_flag & ~cap_clr) | cap_evt;
      end
   end
endmodule

// File: rtl/cc_arbiter.sv
module cc_arbiter
   import cc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cap_set,
   input  logic an_set,
   input  logic ack,
   output logic cap_pend,
   output logic an_pend,
   output logic req,
   output logic id
);
   irq_vec_e grant;
   logic     clr_cap, clr_an;

   always_comb begin
      grant   = cap_pend ? VEC_CAPTURE : VEC_ANALOG;
      clr_cap = ack && cap_pend;
      clr_an  = ack && !cap_pend && an_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_pend <= 1'b0;
         an_pend  <= 1'b0;
      end else begin
         cap_pend <= (cap_pend & ~clr_cap) | cap_set;
         an_pend  <= (an_pend & ~clr_an) | an_set;
      end
   end

   assign req = cap_pend | an_pend;
   assign id  = req ? logic'(grant) : 1'b0;
endmodule

// File: rtl/cmp_capture_ctrl.sv
module cmp_capture_ctrl
   import cc_pkg::*;
#(
   parameter int unsigned TMR_W       = 16,
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [MODE_W-1:0] ctrl_mode,
   input  logic              ctrl_src_sel,
   input  logic              ctrl_irq_en,
   input  logic              ctrl_edge_rise,
   input  logic              flag_clr_we,
   input  logic [2:0]        flag_clr,
   input  logic              cap_pin,
   input  logic              cmp1_out,
   input  logic              cmp2_out,
   input  logic              irq_ack,
   output logic [TMR_W-1:0]  timer_count,
   output logic [TMR_W-1:0]  cap_value,
   output logic              cap_flag,
   output logic [1:0]        cmp_flags,
   output logic              src_sel,
   output logic [MODE_W-1:0] mode,
   output logic              irq_req,
   output logic              irq_id
);
   localparam int unsigned N_IN = 3;

   generate
      if (TMR_W < 2)     begin : g_bad_w $error("TMR_W must be at least 2"); end
      if (MODE_W < 2 || MODE_W > 8) begin : g_bad_m $error("MODE_W must be 2..8"); end
   endgenerate

   logic            irq_en_q, edge_rise_q;
   logic [N_IN-1:0] raw_in, lvl, rise, fall;
   logic            cap_evt, an_set, cap_pend, an_pend;
   logic [2:0]      clr_mask;

   assign raw_in = {cmp2_out, cmp1_out, cap_pin};

   for (genvar g = 0; g < N_IN; g++) begin : g_sync
      cc_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk(clk), .rst_n(rst_n), .din(raw_in[g]),
         .level(lvl[g]), .rise(rise[g]), .fall(fall[g])
      );
   end

   // control register; ramp modes force the comparator as capture source
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode        <= '0;
         irq_en_q    <= 1'b0;
         edge_rise_q <= 1'b0;
         src_sel     <= 1'b0;
      end else if (ctrl_we) begin
         mode        <= ctrl_mode;
         irq_en_q    <= ctrl_irq_en;
         edge_rise_q <= ctrl_edge_rise;
         src_sel     <= ctrl_src_sel | is_ramp_mode(8'(ctrl_mode));
      end
   end

   assign clr_mask = flag_clr_we ? flag_clr : 3'b000;

   always_comb begin
      if (src_sel) cap_evt = edge_rise_q ? rise[2] : fall[2];
      else         cap_evt = edge_rise_q ? rise[0] : fall[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_flags <= 2'b00;
      else        cmp_flags <= (cmp_flags & ~clr_mask[CLR_CMP2:CLR_CMP1]) | rise[2:1];
   end

   assign an_set = irq_en_q & (|cmp_flags);

   cc_capture #(.TMR_W(TMR_W)) i_capture (
      .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cap_clr(clr_mask[CLR_CAP]),
      .timer_count(timer_count), .cap_value(cap_value), .cap_flag(cap_flag)
   );

   cc_arbiter i_arbiter (
      .clk(clk), .rst_n(rst_n), .cap_set(cap_evt), .an_set(an_set), .ack(irq_ack),
      .cap_pend(cap_pend), .an_pend(an_pend), .req(irq_req), .id(irq_id)
   );
endmodule

// File: rtl/cc_capture_chk.sv
module cc_capture_chk #(
   parameter int unsigned TMR_W  = 16,
   parameter int unsigned MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_we,
   input logic [MODE_W-1:0] ctrl_mode,
   input logic              flag_clr_we,
   input logic [2:0]        flag_clr,
   input logic              irq_ack,
   input logic [TMR_W-1:0]  timer_count,
   input logic              cap_flag,
   input logic [1:0]        cmp_flags,
   input logic              src_sel,
   input logic              irq_req,
   input logic              irq_id,
   input logic              irq_en,
   input logic              cap_pend,
   input logic              an_pend
);
   p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> timer_count == TMR_W'($past(timer_count) + 1'b1));

   p_ramp_forces_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we && (ctrl_mode == MODE_W'(2) || ctrl_mode == MODE_W'(3)) |=> src_sel);

   p_cmp1_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_flags[0] && !(flag_clr_we && flag_clr[0]) |=> cmp_flags[0]);

   p_cmp2_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_flags[1] && !(flag_clr_we && flag_clr[1]) |=> cmp_flags[1]);

   p_analog_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en && (|cmp_flags) |=> an_pend);

   p_capture_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pend |-> irq_req && !irq_id);

   p_analog_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
      an_pend && cap_pend && irq_ack |=> an_pend);

   p_capflag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cap_flag && !(flag_clr_we && flag_clr[2]) |=> cap_flag);
endmodule

bind cmp_capture_ctrl cc_capture_chk #(.TMR_W(TMR_W), .MODE_W(MODE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode),
   .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .irq_ack(irq_ack),
   .timer_count(timer_count), .cap_flag(cap_flag), .cmp_flags(cmp_flags),
   .src_sel(src_sel), .irq_req(irq_req), .irq_id(irq_id), .irq_en(irq_en_q),
   .cap_pend(cap_pend), .an_pend(an_pend)
);

// File: tb/test_cmp_capture_ctrl.sv
`timescale 1ns/1ps
module test_cmp_capture_ctrl;
   localparam int W = 8;
   localparam int MW = 2;
   localparam int S = 2;
   localparam int MAX_CYC = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctrl_we = 0, ctrl_src_sel = 0, ctrl_irq_en = 0, ctrl_edge_rise = 0;
   logic [MW-1:0] ctrl_mode = '0;
   logic flag_clr_we = 0;
   logic [2:0] flag_clr = '0;
   logic cap_pin = 0, cmp1_out = 0, cmp2_out = 0, irq_ack = 0;
   logic [W-1:0] timer_count, cap_value;
   logic cap_flag, src_sel, irq_req, irq_id;
   logic [1:0] cmp_flags;
   logic [MW-1:0] mode;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cmp_capture_ctrl #(.TMR_W(W), .MODE_W(MW), .SYNC_STAGES(S)) i_cmp_capture_ctrl (.*);

   // behavioural reference model
   int m_tmr, m_capv, m_mode;
   bit m_capf, m_f1, m_f2, m_src, m_ien, m_edge, m_cp, m_ap;
   bit pd[S+1], c1d[S+1], c2d[S+1];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tmr = 0; m_capv = 0; m_mode = 0;
         {m_capf, m_f1, m_f2, m_src, m_ien, m_edge, m_cp, m_ap} = '0;
         for (int i = 0; i <= S; i++) begin pd[i] = 0; c1d[i] = 0; c2d[i] = 0; end
      end else begin
         bit pr, pf, c1r, c2r, c2f, evt, an, ca, cc;
         pr  = pd[S-1] && !pd[S];   pf = !pd[S-1] && pd[S];
         c1r = c1d[S-1] && !c1d[S];
         c2r = c2d[S-1] && !c2d[S]; c2f = !c2d[S-1] && c2d[S];
         evt = m_src ? (m_edge ? c2r : c2f) : (m_edge ? pr : pf);
         an  = m_ien && (m_f1 || m_f2);
         ca  = irq_ack && m_cp;
         cc  = irq_ack && !m_cp && m_ap;
         m_cp = (m_cp && !ca) || evt;
         m_ap = (m_ap && !cc) || an;
         m_f1 = (m_f1 && !(flag_clr_we && flag_clr[0])) || c1r;
         m_f2 = (m_f2 && !(flag_clr_we && flag_clr[1])) || c2r;
         m_capf = (m_capf && !(flag_clr_we && flag_clr[2])) || evt;
         if (evt) m_capv = m_tmr;
         m_tmr = (m_tmr + 1) % (1 << W);
         if (ctrl_we) begin
            m_mode = ctrl_mode; m_ien = ctrl_irq_en; m_edge = ctrl_edge_rise;
            m_src = ctrl_src_sel || ctrl_mode == 2 || ctrl_mode == 3;
         end
         for (int i = S; i > 0; i--) begin pd[i] = pd[i-1]; c1d[i] = c1d[i-1]; c2d[i] = c2d[i-1]; end
         pd[0] = cap_pin; c1d[0] = cmp1_out; c2d[0] = cmp2_out;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk("R2 timer", timer_count, m_tmr);
      chk("R3/R5/R6 capture value", cap_value, m_capv);
      chk("R11 capture flag", cap_flag, m_capf);
      chk("R7 comparator flags", cmp_flags, {m_f2, m_f1});
      chk("R4 source select", src_sel, m_src);
      chk("R4 mode", mode, m_mode);
      chk("R8/R10 irq request", irq_req, m_cp || m_ap);
      if (m_cp || m_ap) chk("R9 vector", irq_id, m_cp ? 0 : 1);
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      cyc(3);
      chk("R1 reset timer", timer_count, 0);
      chk("R1 reset capture", cap_value, 0);
      chk("R1 reset flags", {cap_flag, cmp_flags, src_sel, irq_req, irq_id}, 0);
      chk("R1 reset mode", mode, 0);
      rst_n = 1;
      cyc(1);
      // R4: ramp mode 3 with src 0 written, expect forced src
      ctrl_we = 1; ctrl_mode = 2'd3; ctrl_src_sel = 0; ctrl_irq_en = 1; ctrl_edge_rise = 1;
      cyc(1); ctrl_we = 0;
      chk("R4 forced source", src_sel, 1);
      // R10 scenario: comparator 2 trips with both routes on
      cmp2_out = 1;
      cyc(4);
      chk("R9 capture pending first", {irq_req, irq_id}, 2'b10);
      chk("R8 analog flag", cmp_flags, 2'b10);
      flag_clr_we = 1; flag_clr = 3'b110; cmp2_out = 0;
      cyc(1); flag_clr_we = 0; flag_clr = 0;
      chk("R11 capture flag cleared", cap_flag, 0);
      irq_ack = 1;
      cyc(1); irq_ack = 0;
      chk("R10 analog survives", {irq_req, irq_id}, 2'b11);
      irq_ack = 1;
      cyc(1); irq_ack = 0;
      chk("R10 analog acknowledged", irq_req, 0);
      // R3 pin source, falling edge
      ctrl_we = 1; ctrl_mode = 2'd0; ctrl_src_sel = 0; ctrl_irq_en = 0; ctrl_edge_rise = 0;
      cyc(1); ctrl_we = 0;
      cap_pin = 1; cyc(5); cap_pin = 0; cyc(S + 1);
      chk("R3 pin capture flag", cap_flag, 1);
      // random phase
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(7) == 0) cap_pin  = ~cap_pin;
         if ($urandom_range(7) == 0) cmp1_out = ~cmp1_out;
         if ($urandom_range(7) == 0) cmp2_out = ~cmp2_out;
         ctrl_we = ($urandom_range(39) == 0);
         ctrl_mode = MW'($urandom_range(3)); ctrl_src_sel = 1'($urandom_range(1));
         ctrl_irq_en = 1'($urandom_range(1)); ctrl_edge_rise = 1'($urandom_range(1));
         flag_clr_we = ($urandom_range(9) == 0); flag_clr = 3'($urandom_range(7));
         irq_ack = ($urandom_range(5) == 0);
         cyc(1);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(MAX_CYC * 5);
      if (!done) begin
         done = 1; checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule